// File: doc/BRIEF.md
# Two-Level Address Translation Lookaside

This block translates 32-bit virtual addresses for a memory system that separates address spaces by an identifier and separates a secure world from a non-secure one. A small fully associative micro-TLB is searched first. Only when it has no matching entry is a larger fully associative main TLB searched. A main-TLB hit is copied into the micro-TLB, so a repeated access to the same page completes on the fast path.

A request carries the virtual address, the current address-space identifier (ASID), the world bit, and the write and privilege flags of the access. The block answers with a physical address and the region attributes of the page. If the domain or permission check denies the access, it answers with an abort instead. If neither level holds a matching entry, it answers with a miss, and an external walker then installs the translation through the refill port. Invalidation can clear every entry, or only the non-global entries that belong to one ASID.

Top module: `xlatTlb`

## Requirements
- R1: The micro-TLB is searched at the edge that accepts a request. On a micro-TLB hit, `respValid` is high in the cycle that directly follows that edge.
- R2: An entry matches only when all three conditions hold: its virtual page equals the request's page under the entry's size mask, its world bit equals `reqNs`, and it is either global or its ASID equals `reqAsid`.
- R3: When neither level holds a matching entry, the response arrives two cycles after acceptance with `respMiss`=1, `respAbort`=0 and `respPa`=0.
- R4: An entry's size code sets how many low address bits pass through unchanged from the virtual to the physical address: 0 is 4 KB (12 bits), 1 is 64 KB (16 bits), 2 is 1 MB (20 bits) and 3 is 16 MB (24 bits). Those same bits are excluded from the page compare.
- R5: `domainCtl` bits [2d+1:2d] give the access type of domain d. The value 00 and the reserved value 10 always abort. The value 11 grants access with no permission check. The value 01 applies the permission check of R6.
- R6: Under a client domain, the 2-bit permission field decides the outcome. 00 denies every access. 01 allows privileged access only. 10 allows privileged access, and user reads but not user writes. 11 allows every access.
- R7: An allowed hit returns the entry's memory type, shareable flag and world bit with `respAbort`=0. A denied hit returns `respAbort`=1, `respMiss`=0, and a physical address and attributes of zero.
- R8: A main-TLB hit responds two cycles after acceptance and copies the entry into the micro-TLB. A repeat of the same request then hits the micro-TLB (R1 timing).
- R9: Promotions fill the micro-TLB slots in round-robin order, and refills fill the main-TLB slots in round-robin order. With a micro-TLB of N slots, the (N+1)th promotion evicts the first promoted page.
- R10: `invalAll` clears every entry in both levels at the next edge. A refill or promotion in the same cycle is dropped.
- R11: `invalAsidEn` clears, in both levels, only the non-global entries whose ASID equals `invalAsid`. Global entries and entries of other ASIDs remain usable.
- R12: `reqReady` is low during the cycle after a request that missed the micro-TLB, and high otherwise. A request is accepted only while `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqVa | input | 32 | Virtual address |
| reqAsid | input | 8 | Current address-space identifier |
| reqNs | input | 1 | Current world, 1 = non-secure |
| reqWrite | input | 1 | Access is a write |
| reqPriv | input | 1 | Access is privileged |
| domainCtl | input | 32 | Access type for each of 16 domains, 2 bits each |
| refillValid | input | 1 | Install an entry in the main TLB |
| refillVpn | input | 20 | Virtual page, address bits [31:12] |
| refillSize | input | 2 | Mapping size code (R4) |
| refillAsid | input | 8 | ASID of the entry |
| refillGlobal | input | 1 | Entry matches every ASID |
| refillNs | input | 1 | World bit of the entry |
| refillPpn | input | 20 | Physical page, address bits [31:12] |
| refillAp | input | 2 | Permission field (R6) |
| refillDomain | input | 4 | Domain number |
| refillMemType | input | 2 | Memory type code, returned unchanged |
| refillShared | input | 1 | Shareable flag |
| invalAll | input | 1 | Invalidate every entry |
| invalAsidEn | input | 1 | Invalidate the non-global entries of one ASID |
| invalAsid | input | 8 | ASID to invalidate |
| respValid | output | 1 | Response present for one cycle |
| respMiss | output | 1 | No translation found |
| respAbort | output | 1 | Access denied |
| respPa | output | 32 | Physical address |
| respMemType | output | 2 | Memory type of the page |
| respShared | output | 1 | Shareable flag of the page |
| respNs | output | 1 | World bit of the page |

## Verification
The hardest state to reach from the ports is a micro-TLB entry that has been overwritten by round-robin promotion while its page still sits in the main TLB. Response latency is the only way to see this from outside. The stimulus refills one more page than the micro-TLB has slots, looks each page up once so that each is promoted in turn, and then measures latency: a surviving page answers in one cycle, and the evicted page answers in two. The ASID invalidation case uses the same latency measurement to show that global entries stay in the micro-TLB.

// File: rtl/xlatPkg.sv
package xlatPkg;

  parameter int ASID_W = 8;
  parameter int DOM_W  = 4;
  localparam int VPN_W = 20;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic              global;
    logic              ns;
    logic [VPN_W-1:0]  ppn;
    logic [1:0]        ap;
    logic [DOM_W-1:0]  domain;
    logic [1:0]        memType;
    logic              shared;
  } tlbEntry_t;

  typedef struct packed {
    logic capture;
    logic promote;
    logic loadMicro;
    logic loadMain;
  } xlatStrobes_t;

  // Page-number bits that take part in the compare for each size code.
  function automatic logic [VPN_W-1:0] vpnMask(input logic [1:0] size);
    case (size)
      2'd0:    return 20'hFFFFF;
      2'd1:    return 20'hFFFF0;
      2'd2:    return 20'hFFF00;
      default: return 20'hFF000;
    endcase
  endfunction

  function automatic logic entryHit(input tlbEntry_t e, input logic [VPN_W-1:0] vpn,
                                    input logic [ASID_W-1:0] asid, input logic ns);
    return e.valid && (((e.vpn ^ vpn) & vpnMask(e.size)) == '0) &&
           (e.ns == ns) && (e.global || (e.asid == asid));
  endfunction

  function automatic logic [31:0] makePa(input tlbEntry_t e, input logic [31:0] va);
    logic [31:0] hiMask;
    hiMask = {vpnMask(e.size), 12'h000};
    return ({e.ppn, 12'h000} & hiMask) | (va & ~hiMask);
  endfunction

  function automatic logic accessOk(input tlbEntry_t e, input logic [31:0] dacr,
                                    input logic priv, input logic write);
    logic [1:0] dField;
    dField = dacr[{e.domain, 1'b0} +: 2];
    case (dField)
      2'b11: return 1'b1;
      2'b01: begin
        case (e.ap)
          2'b00:   return 1'b0;
          2'b01:   return priv;
          2'b10:   return priv || !write;
          default: return 1'b1;
        endcase
      end
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xlatControl.sv
module xlatControl
  import xlatPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         microHit,
  input  logic         mainHit,
  output logic         reqReady,
  output xlatStrobes_t strobes
);

  typedef enum logic {ST_IDLE, ST_MAIN} ctlState_t;
  ctlState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    reqReady  = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.capture = 1'b1;
          if (microHit) strobes.loadMicro = 1'b1;
          else          stateNext = ST_MAIN;
        end
      end
      default: begin
        strobes.loadMain = 1'b1;
        strobes.promote  = mainHit;
        stateNext        = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8: a micro-TLB miss at acceptance is always followed by a main-TLB result
  a_r8_main_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !microHit) |=> strobes.loadMain);

  // R12: the cycle after a micro-TLB miss refuses new requests
  a_r12_busy_after_miss: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !microHit) |=> !reqReady);

endmodule

// File: rtl/xlatDatapath.sv
module xlatDatapath
  import xlatPkg::*;
#(
  parameter int MICRO_N = 4,
  parameter int MAIN_N  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobes_t      strobes,
  input  logic [31:0]       reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqNs,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic [31:0]       domainCtl,
  input  logic              refillValid,
  input  tlbEntry_t         refillEntry,
  input  logic              invalAll,
  input  logic              invalAsidEn,
  input  logic [ASID_W-1:0] invalAsid,
  output logic              microHit,
  output logic              mainHit,
  output logic              respValid,
  output logic              respMiss,
  output logic              respAbort,
  output logic [31:0]       respPa,
  output logic [1:0]        respMemType,
  output logic              respShared,
  output logic              respNs
);

  localparam int MICRO_IW = (MICRO_N > 1) ? $clog2(MICRO_N) : 1;
  localparam int MAIN_IW  = (MAIN_N > 1) ? $clog2(MAIN_N) : 1;

  tlbEntry_t microArr [MICRO_N];
  tlbEntry_t mainArr  [MAIN_N];
  logic [MICRO_IW-1:0] microPtr;
  logic [MAIN_IW-1:0]  mainPtr;
  logic [MICRO_N-1:0]  microValidVec;
  logic [MAIN_N-1:0]   mainValidVec;

  // Captured request for the main-TLB cycle
  logic [31:0]       capVa;
  logic [ASID_W-1:0] capAsid;
  logic              capNs, capWrite, capPriv;

  tlbEntry_t microSel, mainSel;
  logic [MICRO_N-1:0] microMatch;
  logic [MAIN_N-1:0]  mainMatch;

  genvar gi;
  generate
    for (gi = 0; gi < MICRO_N; gi++) begin : g_microCmp
      assign microMatch[gi]    = entryHit(microArr[gi], reqVa[31:12], reqAsid, reqNs);
      assign microValidVec[gi] = microArr[gi].valid;
    end
    for (gi = 0; gi < MAIN_N; gi++) begin : g_mainCmp
      assign mainMatch[gi]    = entryHit(mainArr[gi], capVa[31:12], capAsid, capNs);
      assign mainValidVec[gi] = mainArr[gi].valid;
    end
  endgenerate

  // Lowest-index match wins in each level
  always_comb begin
    microSel = '0;
    for (int i = MICRO_N - 1; i >= 0; i--)
      if (microMatch[i]) microSel = microArr[i];
    mainSel = '0;
    for (int i = MAIN_N - 1; i >= 0; i--)
      if (mainMatch[i]) mainSel = mainArr[i];
  end

  assign microHit = |microMatch;
  assign mainHit  = |mainMatch;

  logic microOk, mainOk;
  assign microOk = accessOk(microSel, domainCtl, reqPriv, reqWrite);
  assign mainOk  = accessOk(mainSel, domainCtl, capPriv, capWrite);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capVa <= '0; capAsid <= '0; capNs <= 1'b0; capWrite <= 1'b0; capPriv <= 1'b0;
    end else if (strobes.capture) begin
      capVa <= reqVa; capAsid <= reqAsid; capNs <= reqNs;
      capWrite <= reqWrite; capPriv <= reqPriv;
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    respValid <= 1'b0; respMiss <= 1'b0; respAbort <= 1'b0;
    respPa <= '0; respMemType <= '0; respShared <= 1'b0; respNs <= 1'b0;
    if (rstN) begin
      if (strobes.loadMicro) begin
        respValid <= 1'b1;
        respAbort <= !microOk;
        if (microOk) begin
          respPa      <= makePa(microSel, reqVa);
          respMemType <= microSel.memType;
          respShared  <= microSel.shared;
          respNs      <= microSel.ns;
        end
      end else if (strobes.loadMain) begin
        respValid <= 1'b1;
        respMiss  <= !mainHit;
        respAbort <= mainHit && !mainOk;
        if (mainHit && mainOk) begin
          respPa      <= makePa(mainSel, capVa);
          respMemType <= mainSel.memType;
          respShared  <= mainSel.shared;
          respNs      <= mainSel.ns;
        end
      end
    end
  end

  // Entry storage: invalidation first, then writes (dropped under invalAll)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MICRO_N; i++) microArr[i] <= '0;
      for (int i = 0; i < MAIN_N; i++)  mainArr[i]  <= '0;
      microPtr <= '0;
      mainPtr  <= '0;
    end else begin
      for (int i = 0; i < MICRO_N; i++) begin
        if (invalAll ||
            (invalAsidEn && !microArr[i].global && microArr[i].asid == invalAsid))
          microArr[i].valid <= 1'b0;
      end
      for (int i = 0; i < MAIN_N; i++) begin
        if (invalAll ||
            (invalAsidEn && !mainArr[i].global && mainArr[i].asid == invalAsid))
          mainArr[i].valid <= 1'b0;
      end
      if (!invalAll && strobes.promote) begin
        microArr[microPtr] <= mainSel;
        microPtr <= (microPtr == MICRO_IW'(MICRO_N - 1)) ? '0 : microPtr + 1'b1;
      end
      if (!invalAll && refillValid) begin
        mainArr[mainPtr]       <= refillEntry;
        mainArr[mainPtr].valid <= 1'b1;
        mainPtr <= (mainPtr == MAIN_IW'(MAIN_N - 1)) ? '0 : mainPtr + 1'b1;
      end
    end
  end

  // R1: a micro-TLB load yields a non-miss response on the next cycle
  a_r1_micro_resp: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMicro |=> (respValid && !respMiss));

  // R7: an aborted access carries no physical address
  a_r7_abort_no_pa: assert property (@(posedge clk) disable iff (!rstN)
    respAbort |-> (respValid && !respMiss && respPa == '0));

  // R10: invalidate-all leaves no valid entry anywhere
  a_r10_inval_all: assert property (@(posedge clk) disable iff (!rstN)
    invalAll |=> (microValidVec == '0 && mainValidVec == '0));

  // R9: a promotion fills the slot the round-robin pointer selected
  a_r9_promote_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.promote && !invalAll) |=> microValidVec[$past(microPtr)]);

endmodule

// File: rtl/xlatTlb.sv
module xlatTlb
  import xlatPkg::*;
#(
  parameter int MICRO_N = 4,
  parameter int MAIN_N  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqNs,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic [31:0]       domainCtl,
  input  logic              refillValid,
  input  logic [19:0]       refillVpn,
  input  logic [1:0]        refillSize,
  input  logic [ASID_W-1:0] refillAsid,
  input  logic              refillGlobal,
  input  logic              refillNs,
  input  logic [19:0]       refillPpn,
  input  logic [1:0]        refillAp,
  input  logic [DOM_W-1:0]  refillDomain,
  input  logic [1:0]        refillMemType,
  input  logic              refillShared,
  input  logic              invalAll,
  input  logic              invalAsidEn,
  input  logic [ASID_W-1:0] invalAsid,
  output logic              respValid,
  output logic              respMiss,
  output logic              respAbort,
  output logic [31:0]       respPa,
  output logic [1:0]        respMemType,
  output logic              respShared,
  output logic              respNs
);

  xlatStrobes_t strobes;
  logic microHit, mainHit;
  tlbEntry_t refillEntry;

  always_comb begin
    refillEntry         = '0;
    refillEntry.vpn     = refillVpn;
    refillEntry.size    = refillSize;
    refillEntry.asid    = refillAsid;
    refillEntry.global  = refillGlobal;
    refillEntry.ns      = refillNs;
    refillEntry.ppn     = refillPpn;
    refillEntry.ap      = refillAp;
    refillEntry.domain  = refillDomain;
    refillEntry.memType = refillMemType;
    refillEntry.shared  = refillShared;
  end

  xlatControl ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .microHit(microHit),
    .mainHit(mainHit), .reqReady(reqReady), .strobes(strobes)
  );

  xlatDatapath #(.MICRO_N(MICRO_N), .MAIN_N(MAIN_N)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqVa(reqVa), .reqAsid(reqAsid), .reqNs(reqNs), .reqWrite(reqWrite),
    .reqPriv(reqPriv), .domainCtl(domainCtl),
    .refillValid(refillValid), .refillEntry(refillEntry),
    .invalAll(invalAll), .invalAsidEn(invalAsidEn), .invalAsid(invalAsid),
    .microHit(microHit), .mainHit(mainHit),
    .respValid(respValid), .respMiss(respMiss), .respAbort(respAbort),
    .respPa(respPa), .respMemType(respMemType), .respShared(respShared),
    .respNs(respNs)
  );

endmodule

// File: tb/xlatTlb_tb.sv
module xlatTlb_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqNs = 0, reqWrite = 0, reqPriv = 0;
  logic [31:0] reqVa = '0, domainCtl = '0;
  logic [7:0] reqAsid = '0, refillAsid = '0, invalAsid = '0;
  logic refillValid = 0, refillGlobal = 0, refillNs = 0, refillShared = 0;
  logic [19:0] refillVpn = '0, refillPpn = '0;
  logic [1:0] refillSize = '0, refillAp = '0, refillMemType = '0;
  logic [3:0] refillDomain = '0;
  logic invalAll = 0, invalAsidEn = 0;
  logic reqReady, respValid, respMiss, respAbort, respShared, respNs;
  logic [31:0] respPa;
  logic [1:0] respMemType;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  // Results of the last lookup
  int gLat; logic gReady, gMiss, gAbort, gShared, gNs;
  logic [31:0] gPa; logic [1:0] gMt;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlatTlb dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqAsid(reqAsid), .reqNs(reqNs), .reqWrite(reqWrite),
    .reqPriv(reqPriv), .domainCtl(domainCtl), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillSize(refillSize), .refillAsid(refillAsid),
    .refillGlobal(refillGlobal), .refillNs(refillNs), .refillPpn(refillPpn),
    .refillAp(refillAp), .refillDomain(refillDomain), .refillMemType(refillMemType),
    .refillShared(refillShared), .invalAll(invalAll), .invalAsidEn(invalAsidEn),
    .invalAsid(invalAsid), .respValid(respValid), .respMiss(respMiss),
    .respAbort(respAbort), .respPa(respPa), .respMemType(respMemType),
    .respShared(respShared), .respNs(respNs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic refill(logic [19:0] vpn, logic [1:0] sz, logic [7:0] asid, logic glob,
                        logic ns, logic [19:0] ppn, logic [1:0] ap, logic [3:0] dom,
                        logic [1:0] mt, logic sh);
    @(negedge clk);
    refillValid = 1; refillVpn = vpn; refillSize = sz; refillAsid = asid;
    refillGlobal = glob; refillNs = ns; refillPpn = ppn; refillAp = ap;
    refillDomain = dom; refillMemType = mt; refillShared = sh;
    @(negedge clk);
    refillValid = 0;
  endtask

  task automatic lookup(logic [31:0] va, logic [7:0] asid, logic ns, logic wr, logic pv);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqVa = va; reqAsid = asid; reqNs = ns; reqWrite = wr; reqPriv = pv;
    @(negedge clk);
    reqValid = 0;
    gReady = reqReady;
    gLat = 1;
    while (!respValid && gLat < 5) begin
      @(negedge clk);
      gLat++;
    end
    gMiss = respMiss; gAbort = respAbort; gPa = respPa;
    gMt = respMemType; gShared = respShared; gNs = respNs;
  endtask

  task automatic flushAll();
    @(negedge clk); invalAll = 1;
    @(negedge clk); invalAll = 0;
  endtask

  task automatic testReset();
    chk("R12 reset ready", reqReady, 1);
    chk("R3 reset respValid", respValid, 0);
    lookup(32'h1234_5678, 8'd1, 1'b0, 1'b0, 1'b1);
    chk("R3 empty miss", gMiss, 1);
    chk("R3 empty miss latency", gLat, 2);
    chk("R3 miss no abort", gAbort, 0);
    chk("R3 miss pa zero", gPa, 0);
  endtask

  task automatic testSizes();
    flushAll();
    domainCtl = 32'h0000_000C;  // domain 1 manager
    refill(20'h12345, 2'd0, 8'd1, 1'b1, 1'b0, 20'hABCDE, 2'b11, 4'd1, 2'b10, 1'b0);
    refill(20'h00020, 2'd1, 8'd1, 1'b1, 1'b0, 20'h00330, 2'b11, 4'd1, 2'b10, 1'b0);
    refill(20'h00100, 2'd2, 8'd1, 1'b1, 1'b0, 20'h80000, 2'b11, 4'd1, 2'b10, 1'b0);
    refill(20'h01000, 2'd3, 8'd1, 1'b1, 1'b0, 20'h05000, 2'b11, 4'd1, 2'b10, 1'b0);
    lookup(32'h1234_5678, 8'd1, 0, 0, 1); chk("R4 4K pa", gPa, 32'hABCD_E678);
    lookup(32'h0002_F123, 8'd1, 0, 0, 1); chk("R4 64K pa", gPa, 32'h0033_F123);
    lookup(32'h001A_BCDE, 8'd1, 0, 0, 1); chk("R4 1M pa", gPa, 32'h800A_BCDE);
    lookup(32'h0123_4567, 8'd1, 0, 0, 1); chk("R4 16M pa", gPa, 32'h0523_4567);
    lookup(32'h1234_6000, 8'd1, 0, 0, 1); chk("R4 4K neighbour miss", gMiss, 1);
  endtask

  task automatic testMatch();
    flushAll();
    domainCtl = 32'h0000_000C;
    refill(20'h40000, 2'd0, 8'd5, 1'b0, 1'b1, 20'h11111, 2'b11, 4'd1, 2'b01, 1'b1);
    refill(20'h50000, 2'd0, 8'd5, 1'b1, 1'b1, 20'h22222, 2'b11, 4'd1, 2'b01, 1'b0);
    lookup(32'h4000_0010, 8'd6, 1, 0, 1); chk("R2 other asid miss", gMiss, 1);
    lookup(32'h4000_0010, 8'd5, 0, 0, 1); chk("R2 other world miss", gMiss, 1);
    lookup(32'h4000_0010, 8'd5, 1, 0, 1);
    chk("R2 exact hit", gMiss, 0); chk("R2 exact pa", gPa, 32'h1111_1010);
    chk("R7 memType", gMt, 2'b01); chk("R7 shared", gShared, 1); chk("R7 ns", gNs, 1);
    lookup(32'h5000_0020, 8'd9, 1, 0, 1);
    chk("R2 global any asid", gMiss, 0); chk("R2 global pa", gPa, 32'h2222_2020);
  endtask

  task automatic testPromote();
    flushAll();
    domainCtl = 32'h0000_000C;
    refill(20'h60000, 2'd0, 8'd2, 1'b0, 1'b0, 20'h33333, 2'b11, 4'd1, 2'b10, 1'b0);
    lookup(32'h6000_0004, 8'd2, 0, 0, 1);
    chk("R8 main hit latency", gLat, 2); chk("R12 busy after micro miss", gReady, 0);
    chk("R8 main hit pa", gPa, 32'h3333_3004);
    lookup(32'h6000_0008, 8'd2, 0, 0, 1);
    chk("R1 micro hit latency", gLat, 1); chk("R12 ready after micro hit", gReady, 1);
    chk("R1 micro hit pa", gPa, 32'h3333_3008);
  endtask

  task automatic testRoundRobin();
    flushAll();
    domainCtl = 32'h0000_000C;
    for (int i = 0; i < 5; i++)
      refill(20'h70000 + 20'(i), 2'd0, 8'd3, 1'b0, 1'b0, 20'h90000 + 20'(i),
             2'b11, 4'd1, 2'b10, 1'b0);
    for (int i = 0; i < 5; i++) lookup(32'h7000_0000 + 32'(i) * 32'h1000, 8'd3, 0, 0, 1);
    lookup(32'h7000_1000, 8'd3, 0, 0, 1); chk("R9 survivor in micro", gLat, 1);
    lookup(32'h7000_0000, 8'd3, 0, 0, 1); chk("R9 first promoted evicted", gLat, 2);
    chk("R9 evicted still in main", gPa, 32'h9000_0000);
    lookup(32'h7000_2000, 8'd3, 0, 0, 1); chk("R9 third survivor", gLat, 1);
  endtask

  task automatic testPerm();
    flushAll();
    domainCtl = 32'h0000_00B4;  // d0=00 d1=01 d2=11 d3=10
    refill(20'hA0000, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0000, 2'b00, 4'd2, 2'b10, 1'b1);
    refill(20'hA0001, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0001, 2'b11, 4'd0, 2'b10, 1'b1);
    refill(20'hA0002, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0002, 2'b11, 4'd3, 2'b10, 1'b1);
    refill(20'hA0003, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0003, 2'b00, 4'd1, 2'b10, 1'b1);
    refill(20'hA0004, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0004, 2'b01, 4'd1, 2'b10, 1'b1);
    refill(20'hA0005, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0005, 2'b10, 4'd1, 2'b10, 1'b1);
    refill(20'hA0006, 2'd0, 8'd1, 1'b1, 1'b0, 20'hC0006, 2'b11, 4'd1, 2'b10, 1'b1);
    lookup(32'hA000_0000, 8'd1, 0, 1, 0); chk("R5 manager skips ap", gAbort, 0);
    chk("R5 manager pa", gPa, 32'hC000_0000);
    lookup(32'hA000_1000, 8'd1, 0, 0, 1); chk("R5 no-access domain", gAbort, 1);
    chk("R7 abort pa zero", gPa, 0); chk("R7 abort no miss", gMiss, 0);
    chk("R7 abort attrs zero", {gMt, gShared}, 0);
    lookup(32'hA000_2000, 8'd1, 0, 0, 1); chk("R5 reserved domain", gAbort, 1);
    lookup(32'hA000_3000, 8'd1, 0, 0, 1); chk("R6 ap00 priv denied", gAbort, 1);
    lookup(32'hA000_4000, 8'd1, 0, 1, 1); chk("R6 ap01 priv ok", gAbort, 0);
    lookup(32'hA000_4000, 8'd1, 0, 0, 0); chk("R6 ap01 user denied", gAbort, 1);
    lookup(32'hA000_5000, 8'd1, 0, 0, 0); chk("R6 ap10 user read ok", gAbort, 0);
    lookup(32'hA000_5000, 8'd1, 0, 1, 0); chk("R6 ap10 user write denied", gAbort, 1);
    lookup(32'hA000_6000, 8'd1, 0, 1, 0); chk("R6 ap11 user write ok", gAbort, 0);
  endtask

  task automatic testInval();
    flushAll();
    domainCtl = 32'h0000_000C;
    refill(20'hB0000, 2'd0, 8'd3, 1'b0, 1'b0, 20'hD0000, 2'b11, 4'd1, 2'b10, 1'b0);
    refill(20'hB0001, 2'd0, 8'd3, 1'b1, 1'b0, 20'hD0001, 2'b11, 4'd1, 2'b10, 1'b0);
    refill(20'hB0002, 2'd0, 8'd4, 1'b0, 1'b0, 20'hD0002, 2'b11, 4'd1, 2'b10, 1'b0);
    for (int i = 0; i < 3; i++)
      lookup(32'hB000_0000 + 32'(i) * 32'h1000, (i == 2) ? 8'd4 : 8'd3, 0, 0, 1);
    @(negedge clk); invalAsidEn = 1; invalAsid = 8'd3;
    @(negedge clk); invalAsidEn = 0;
    lookup(32'hB000_0000, 8'd3, 0, 0, 1); chk("R11 asid entry gone", gMiss, 1);
    lookup(32'hB000_1000, 8'd3, 0, 0, 1); chk("R11 global kept in micro", gLat, 1);
    chk("R11 global hit", gMiss, 0);
    lookup(32'hB000_2000, 8'd4, 0, 0, 1); chk("R11 other asid kept", gLat, 1);
    flushAll();
    lookup(32'hB000_1000, 8'd3, 0, 0, 1); chk("R10 all gone", gMiss, 1);
    chk("R10 miss latency", gLat, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSizes();
    testMatch();
    testPromote();
    testRoundRobin();
    testPerm();
    testInval();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule